// File: doc/BRIEF.md
# Decoder Output Post-Processor

This block sits directly behind a convolutional decoder in a broadcast receiver. Every decoded bit is first descrambled: it is XORed with a 9-bit pseudo-random sequence that restarts at each logical frame. Ordinary service bits are then passed to the output only while the selected sub-channel window is open, and an output clock enable marks each bit that is delivered. Bits of the fast information channel do not go to the output. They are packed into bytes and kept in a small buffer that the host can read, and each 32-byte block of them is checked against its 16-bit CRC.

Alongside the data path, the block estimates the channel quality. It compares each decoded bit with the hard-decision received bit, which arrives already delayed to match the decoder latency. It keeps one saturating mismatch counter per sub-channel window. The host reads a counter through a selector and clears it with a read strobe.

Top module: `dec_post_proc`

## Requirements
- R1: While reset is asserted and directly after it, `outEn`, `crcDone` and `crcOk` are 0, every error counter reads 0 and every buffer location reads 0.
- R2: Each bit with `bitValid`=1 is XORed with one sequence bit p(n) = p(n-9) XOR p(n-5). The nine bits before the first bit of a frame count as ones, so a frame starts with 0,0,0,0,0,1,1,1. The sequence advances on every valid bit, whether it belongs to the fast channel or to a service.
- R3: `frameStart` restarts the sequence and resets the byte, buffer and block positions to zero. When it arrives together with a valid bit, that bit is the first bit of the new frame.
- R4: One cycle after a valid bit with `ficBit`=0 and `winEn`=1, `outEn` is 1 and `dataOut` carries the descrambled bit. In every other cycle `outEn` is 0 and `dataOut` keeps its last value.
- R5: A valid bit with `winEn`=1 whose `decBit` differs from `rxBit` adds one to the counter selected by `winId`. The comparison uses the bits before descrambling. With `winEn`=0 nothing is counted.
- R6: A counter that has reached 2^CNT_W-1 stays there when more mismatches arrive.
- R7: `errCount` shows the counter selected by `errSel` combinationally. With `errRd`=1 that counter is cleared at the clock edge. If a mismatch for the same counter falls in the same cycle, the counter becomes 1.
- R8: Descrambled fast-channel bits are packed MSB first into bytes. The bytes are written to consecutive buffer addresses starting at 0, and the address wraps from 95 back to 0. `bufData` shows the byte at `bufAddr` without delay, and addresses from 96 upward read 0.
- R9: Each run of 32 fast-channel bytes forms one block. Its last two bytes, high byte first, hold the inverted CRC of the first 30 bytes. That CRC uses polynomial 0x1021, is preset to 0xFFFF and takes bits MSB first. `crcDone` pulses for one cycle after the block's last bit. `crcOk` then reports a match and holds until the next block ends.
- R10: Fast-channel bits never raise `outEn`, whatever `winEn` is. Their storage and CRC do not depend on `winEn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| bitValid | input | 1 | A decoded bit is present this cycle |
| decBit | input | 1 | Decoded bit, still scrambled |
| rxBit | input | 1 | Latency-matched hard-decision received bit |
| ficBit | input | 1 | Current bit belongs to the fast information channel |
| frameStart | input | 1 | First cycle of a logical frame |
| winEn | input | 1 | Sub-channel window is open |
| winId | input | WIN_W | Window whose error counter is charged |
| errRd | input | 1 | Host read strobe, clears the selected counter |
| errSel | input | WIN_W | Counter selected for reading |
| bufAddr | input | 7 | Host read address into the byte buffer |
| dataOut | output | 1 | Descrambled output bit |
| outEn | output | 1 | Output clock enable |
| errCount | output | CNT_W | Selected error counter |
| crcDone | output | 1 | A fast-channel block has just ended |
| crcOk | output | 1 | Result of the latest block check |
| bufData | output | 8 | Byte read from the buffer |

## Verification
Two pairs of events can fall in the same cycle. A host clear can coincide with a mismatch on the same counter, and a frame restart can coincide with a valid bit. The bench forces both pairs on purpose, checks the collision result against the rules in R3 and R7, and then runs long random traffic in which both pairs occur by chance. A behavioural model built from queues and integers predicts every output and is compared with the design on every clock. This covers the descrambled stream, the counters, the buffer contents and the CRC verdicts of good and deliberately corrupted blocks.

// File: rtl/pp_pkg.sv
package pp_pkg;
  timeunit 1ns; timeprecision 100ps;

  localparam int BUF_BYTES = 96;
  localparam int BUF_AW = $clog2(BUF_BYTES);
  localparam int SEED_W = 9;
  localparam int TAP_HI = SEED_W - 1;
  localparam int TAP_LO = SEED_W - 5;
  localparam logic [15:0] CRC_POLY = 16'h1021;
  localparam logic [15:0] CRC_RESIDUE = 16'h1D0F;

  typedef struct packed {
    logic              takeBit;
    logic              seedLoad;
    logic              ficStep;
    logic              byteWr;
    logic [BUF_AW-1:0] wrAddr;
    logic              crcPreset;
    logic              crcFinal;
    logic              outGate;
    logic              errInc;
    logic              errClr;
  } ppStrobe_t;
endpackage

// File: rtl/pp_ctrl.sv
module pp_ctrl
  import pp_pkg::*;
#(
  parameter int BLK_BYTES = 32
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      bitValid,
  input  logic      ficBit,
  input  logic      frameStart,
  input  logic      winEn,
  input  logic      decBit,
  input  logic      rxBit,
  input  logic      errRd,
  output ppStrobe_t stb
);
  timeunit 1ns; timeprecision 100ps;

  localparam int BLK_BITS = BLK_BYTES * 8;
  localparam int BLK_W = $clog2(BLK_BITS);
  localparam logic [BLK_W-1:0] BLK_LAST = BLK_W'(BLK_BITS - 1);
  localparam logic [BUF_AW-1:0] BUF_LAST = BUF_AW'(BUF_BYTES - 1);

  logic [2:0]        bitIdx, bitNow;
  logic [BUF_AW-1:0] byteIdx, byteNow;
  logic [BLK_W-1:0]  blkBit, blkNow;
  logic              ficStep;

  // A frame restart takes effect for the bit arriving in the same cycle.
  always_comb begin
    bitNow  = frameStart ? '0 : bitIdx;
    byteNow = frameStart ? '0 : byteIdx;
    blkNow  = frameStart ? '0 : blkBit;
    ficStep = bitValid && ficBit;

    stb           = '0;
    stb.takeBit   = bitValid;
    stb.seedLoad  = frameStart;
    stb.ficStep   = ficStep;
    stb.byteWr    = ficStep && (bitNow == 3'd7);
    stb.wrAddr    = byteNow;
    stb.crcPreset = ficStep && (blkNow == '0);
    stb.crcFinal  = ficStep && (blkNow == BLK_LAST);
    stb.outGate   = bitValid && !ficBit && winEn;
    stb.errInc    = bitValid && winEn && (decBit != rxBit);
    stb.errClr    = errRd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitIdx  <= '0;
      byteIdx <= '0;
      blkBit  <= '0;
    end else if (ficStep) begin
      bitIdx <= bitNow + 3'd1;
      if (bitNow == 3'd7)
        byteIdx <= (byteNow == BUF_LAST) ? '0 : byteNow + BUF_AW'(1);
      else
        byteIdx <= byteNow;
      blkBit <= (blkNow == BLK_LAST) ? '0 : blkNow + BLK_W'(1);
    end else if (frameStart) begin
      bitIdx  <= '0;
      byteIdx <= '0;
      blkBit  <= '0;
    end
  end
endmodule

// File: rtl/pp_datapath.sv
module pp_datapath
  import pp_pkg::*;
#(
  parameter int NUM_WIN = 4,
  parameter int CNT_W = 8,
  localparam int WIN_W = $clog2(NUM_WIN)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ppStrobe_t         stb,
  input  logic              decBit,
  input  logic [WIN_W-1:0]  winId,
  input  logic [WIN_W-1:0]  errSel,
  input  logic [BUF_AW-1:0] bufAddr,
  output logic              dataOut,
  output logic              outEn,
  output logic              crcDone,
  output logic              crcOk,
  output logic [CNT_W-1:0]  errCount,
  output logic [7:0]        bufData
);
  timeunit 1ns; timeprecision 100ps;

  localparam logic [SEED_W-1:0] SEED_ONES = '1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [SEED_W-1:0] prbsQ, prbsCur;
  logic              prbsBit, clearBit;
  logic [6:0]        shReg;
  logic [7:0]        byteNow;
  logic [15:0]       crcQ, crcCur, crcNext;
  logic              crcFb;
  logic [7:0]        bufMem [BUF_BYTES];
  logic [CNT_W-1:0]  cntAll [NUM_WIN];

  always_comb begin
    prbsCur  = stb.seedLoad ? SEED_ONES : prbsQ;
    prbsBit  = prbsCur[TAP_HI] ^ prbsCur[TAP_LO];
    clearBit = decBit ^ prbsBit;
    byteNow  = {shReg, clearBit};
    crcCur   = stb.crcPreset ? 16'hFFFF : crcQ;
    crcFb    = crcCur[15] ^ clearBit;
    crcNext  = {crcCur[14:0], 1'b0} ^ (crcFb ? CRC_POLY : 16'h0000);
  end

  // Descrambler state and output stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prbsQ   <= SEED_ONES;
      dataOut <= 1'b0;
      outEn   <= 1'b0;
    end else begin
      if (stb.takeBit)       prbsQ <= {prbsCur[SEED_W-2:0], prbsBit};
      else if (stb.seedLoad) prbsQ <= SEED_ONES;
      outEn <= stb.outGate;
      if (stb.outGate) dataOut <= clearBit;
    end
  end

  // Byte packing and block check
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg   <= '0;
      crcQ    <= 16'hFFFF;
      crcDone <= 1'b0;
      crcOk   <= 1'b0;
    end else begin
      if (stb.ficStep) begin
        shReg <= byteNow[6:0];
        crcQ  <= crcNext;
      end
      crcDone <= stb.crcFinal;
      if (stb.crcFinal) crcOk <= (crcNext == CRC_RESIDUE);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < BUF_BYTES; i++) bufMem[i] <= '0;
    end else if (stb.byteWr) begin
      bufMem[stb.wrAddr] <= byteNow;
    end
  end

  assign bufData = (bufAddr < BUF_AW'(BUF_BYTES)) ? bufMem[bufAddr] : 8'h00;

  // One saturating counter per window
  for (genvar w = 0; w < NUM_WIN; w++) begin : g_cnt
    logic [CNT_W-1:0] cnt;
    logic hitInc, hitClr;
    assign hitInc = stb.errInc && (winId == WIN_W'(w));
    assign hitClr = stb.errClr && (errSel == WIN_W'(w));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                          cnt <= '0;
      else if (hitClr)                    cnt <= hitInc ? CNT_W'(1) : '0;
      else if (hitInc && cnt != CNT_MAX)  cnt <= cnt + CNT_W'(1);
    end
    assign cntAll[w] = cnt;
  end

  assign errCount = cntAll[errSel];
endmodule

// File: rtl/dec_post_proc.sv
module dec_post_proc
  import pp_pkg::*;
#(
  parameter int NUM_WIN = 4,
  parameter int CNT_W = 8,
  parameter int BLK_BYTES = 32,
  localparam int WIN_W = $clog2(NUM_WIN)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitValid,
  input  logic              decBit,
  input  logic              rxBit,
  input  logic              ficBit,
  input  logic              frameStart,
  input  logic              winEn,
  input  logic [WIN_W-1:0]  winId,
  input  logic              errRd,
  input  logic [WIN_W-1:0]  errSel,
  input  logic [BUF_AW-1:0] bufAddr,
  output logic              dataOut,
  output logic              outEn,
  output logic [CNT_W-1:0]  errCount,
  output logic              crcDone,
  output logic              crcOk,
  output logic [7:0]        bufData
);
  timeunit 1ns; timeprecision 100ps;

  ppStrobe_t stb;

  pp_ctrl #(.BLK_BYTES(BLK_BYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .bitValid(bitValid), .ficBit(ficBit),
    .frameStart(frameStart), .winEn(winEn), .decBit(decBit), .rxBit(rxBit),
    .errRd(errRd), .stb(stb)
  );

  pp_datapath #(.NUM_WIN(NUM_WIN), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .decBit(decBit), .winId(winId),
    .errSel(errSel), .bufAddr(bufAddr), .dataOut(dataOut), .outEn(outEn),
    .crcDone(crcDone), .crcOk(crcOk), .errCount(errCount), .bufData(bufData)
  );
endmodule

// File: rtl/pp_checker.sv
module pp_checker #(
  parameter int CNT_W = 8,
  parameter int WIN_W = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             bitValid,
  input logic             decBit,
  input logic             rxBit,
  input logic             ficBit,
  input logic             winEn,
  input logic [WIN_W-1:0] winId,
  input logic             errRd,
  input logic [WIN_W-1:0] errSel,
  input logic             dataOut,
  input logic             outEn,
  input logic [CNT_W-1:0] errCount,
  input logic             crcDone
);
  timeunit 1ns; timeprecision 100ps;

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // R4
  out_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitValid && winEn && !ficBit |=> outEn);

  // R4
  out_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(bitValid && winEn && !ficBit) |=> !outEn && $stable(dataOut));

  // R10
  fic_no_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitValid && ficBit |=> !outEn);

  // R9
  crc_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    crcDone |-> $past(bitValid && ficBit));

  // R6
  err_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    errCount == CNT_MAX && !errRd |=> errCount == CNT_MAX || errSel != $past(errSel));

  // R7
  err_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    errRd && !(bitValid && winEn && decBit != rxBit && winId == errSel)
    |=> errCount == '0 || errSel != $past(errSel));
endmodule

bind dec_post_proc pp_checker #(.CNT_W(CNT_W), .WIN_W(WIN_W)) u_chk (
  .clk(clk), .rstN(rstN), .bitValid(bitValid), .decBit(decBit), .rxBit(rxBit),
  .ficBit(ficBit), .winEn(winEn), .winId(winId), .errRd(errRd), .errSel(errSel),
  .dataOut(dataOut), .outEn(outEn), .errCount(errCount), .crcDone(crcDone)
);

// File: tb/dec_post_proc_test.sv
module dec_post_proc_test;
  timeunit 1ns; timeprecision 100ps;

  localparam int NW = 4;
  localparam int CW = 8;
  localparam int BB = 32;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0, rstN = 1'b0;
  logic bitValid = 0, decBit = 0, rxBit = 0, ficBit = 0, frameStart = 0, winEn = 0;
  logic [1:0] winId = '0, errSel = '0;
  logic errRd = 0;
  logic [6:0] bufAddr = '0;
  logic dataOut, outEn, crcDone, crcOk;
  logic [CW-1:0] errCount;
  logic [7:0] bufData;

  dec_post_proc #(.NUM_WIN(NW), .CNT_W(CW), .BLK_BYTES(BB)) uut (
    .clk(clk), .rstN(rstN), .bitValid(bitValid), .decBit(decBit), .rxBit(rxBit),
    .ficBit(ficBit), .frameStart(frameStart), .winEn(winEn), .winId(winId),
    .errRd(errRd), .errSel(errSel), .bufAddr(bufAddr), .dataOut(dataOut),
    .outEn(outEn), .errCount(errCount), .crcDone(crcDone), .crcOk(crcOk),
    .bufData(bufData)
  );

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  bit started = 0, finished = 0;

  // behavioural reference state
  bit hist[$];
  int cnt[NW];
  int mem[96];
  int wrPtr, nb, curByte;
  int blk[$];
  bit eOutEn, eData, eDone, eOk;
  int lastBlk[$];

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int crcCalc(int b[$]);
    int c = 'hFFFF;
    for (int i = 0; i < BB - 2; i++)
      for (int k = 7; k >= 0; k--) begin
        int fb = ((c >> 15) & 1) ^ ((b[i] >> k) & 1);
        c = (c << 1) & 'hFFFF;
        if (fb != 0) c = c ^ 'h1021;
      end
    return c;
  endfunction

  function automatic bit crcGood(int b[$]);
    int c = crcCalc(b);
    return ((b[BB-2] << 8) | b[BB-1]) == ((~c) & 'hFFFF);
  endfunction

  task automatic seedOnes();
    hist.delete();
    for (int i = 0; i < 9; i++) hist.push_back(1'b1);
  endtask

  // reference model advanced at each rising edge
  always @(posedge clk) begin
    if (!rstN) begin
      seedOnes();
      for (int i = 0; i < NW; i++) cnt[i] = 0;
      for (int i = 0; i < 96; i++) mem[i] = 0;
      wrPtr = 0; nb = 0; curByte = 0; blk.delete();
      eOutEn = 0; eData = 0; eDone = 0; eOk = 0;
    end else begin
      bit mis, p, clr;
      eOutEn = 0; eDone = 0;
      mis = bitValid && winEn && (decBit != rxBit);
      if (mis && !(errRd && winId == errSel) && cnt[winId] < CMAX) cnt[winId]++;
      if (errRd) cnt[errSel] = (mis && winId == errSel) ? 1 : 0;
      if (frameStart) begin
        seedOnes(); wrPtr = 0; nb = 0; curByte = 0; blk.delete();
      end
      if (bitValid) begin
        p = hist[0] ^ hist[4];
        hist.push_back(p);
        void'(hist.pop_front());
        clr = decBit ^ p;
        if (!ficBit && winEn) begin eOutEn = 1; eData = clr; end
        if (ficBit) begin
          curByte = ((curByte << 1) | int'(clr)) & 255;
          nb++;
          if (nb == 8) begin
            mem[wrPtr] = curByte;
            blk.push_back(curByte);
            wrPtr = (wrPtr + 1) % 96;
            nb = 0; curByte = 0;
            if (blk.size() == BB) begin
              eDone = 1; eOk = crcGood(blk); blk.delete();
            end
          end
        end
      end
    end
  end

  // compare with the model on every clock
  always @(posedge clk) begin
    #2;
    if (started && rstN) begin
      chk(outEn == eOutEn, "R4 outEn", int'(outEn), int'(eOutEn));
      chk(dataOut == eData, "R2 dataOut", int'(dataOut), int'(eData));
      chk(crcDone == eDone, "R9 crcDone", int'(crcDone), int'(eDone));
      chk(crcOk == eOk, "R9 crcOk", int'(crcOk), int'(eOk));
      chk(int'(errCount) == cnt[errSel], "R5 errCount", int'(errCount), cnt[errSel]);
      chk(int'(bufData) == ((bufAddr < 96) ? mem[bufAddr] : 0), "R8 bufData",
          int'(bufData), (bufAddr < 96) ? mem[bufAddr] : 0);
    end
  end

  task automatic drive(bit v, bit f, bit fs, bit d, bit r, bit we, int wid);
    @(negedge clk);
    bitValid = v; ficBit = f; frameStart = fs; decBit = d; rxBit = r;
    winEn = we; winId = wid[1:0];
  endtask

  task automatic idle();
    drive(0, 0, 0, 0, 0, 0, 0);
    errRd = 0;
  endtask

  task automatic sendFic(bit b, bit fs, bit we);
    @(negedge clk);
    bitValid = 1; ficBit = 1; frameStart = fs; winEn = we; winId = 0;
    decBit = b ^ (fs ? 1'b0 : (hist[0] ^ hist[4]));
    rxBit = decBit;
  endtask

  task automatic sendBlock(bit corrupt, bit fs, bit we);
    int b[$];
    int c;
    for (int i = 0; i < BB - 2; i++) b.push_back(int'($urandom_range(0, 255)));
    c = crcCalc(b);
    b.push_back(((~c) >> 8) & 255);
    b.push_back((~c) & 255);
    if (corrupt) b[3] = b[3] ^ 'h10;
    for (int i = 0; i < BB; i++)
      for (int k = 7; k >= 0; k--)
        sendFic(b[i][k], fs && i == 0 && k == 7, we);
    lastBlk = b;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seq[8] = '{0, 0, 0, 0, 0, 1, 1, 1};
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(outEn == 0, "R1 outEn", int'(outEn), 0);
    chk(crcDone == 0, "R1 crcDone", int'(crcDone), 0);
    chk(crcOk == 0, "R1 crcOk", int'(crcOk), 0);
    chk(errCount == 0, "R1 errCount", int'(errCount), 0);
    chk(bufData == 0, "R1 bufData", int'(bufData), 0);
    @(negedge clk);
    rstN = 1;
    started = 1;

    // R2 sequence head after frame start, decoded zeros
    for (int i = 0; i < 8; i++) begin
      drive(1, 0, i == 0, 0, 0, 1, 0);
      @(posedge clk); #1;
      chk(dataOut == seq[i][0], "R2 prbs head", int'(dataOut), seq[i]);
      chk(outEn == 1, "R4 enable", int'(outEn), 1);
    end
    idle();
    @(posedge clk); #1;
    chk(outEn == 0, "R4 idle", int'(outEn), 0);

    // R3 restart together with a valid bit
    repeat (5) drive(1, 0, 0, 0, 0, 1, 0);
    drive(1, 0, 1, 1, 1, 1, 0);
    @(posedge clk); #1;
    chk(dataOut == 1, "R3 restart bit", int'(dataOut), 1);
    idle();

    // R5 counting with window open and closed
    errSel = 1;
    repeat (5) drive(1, 0, 0, 1, 0, 1, 1);
    repeat (3) drive(1, 0, 0, 1, 0, 0, 1);
    repeat (2) drive(1, 0, 0, 1, 1, 1, 1);
    idle();
    @(posedge clk); #1;
    chk(errCount == 5, "R5 count", int'(errCount), 5);

    // R6 saturation
    errSel = 2;
    repeat (300) drive(1, 0, 0, 0, 1, 1, 2);
    idle();
    @(posedge clk); #1;
    chk(errCount == CMAX, "R6 saturate", int'(errCount), CMAX);

    // R7 read then clear
    @(negedge clk);
    errRd = 1;
    #1;
    chk(errCount == CMAX, "R7 value before clear", int'(errCount), CMAX);
    @(posedge clk); #1;
    chk(errCount == 0, "R7 cleared", int'(errCount), 0);
    idle();
    // R7 clear colliding with a mismatch on the same counter
    drive(1, 0, 0, 1, 0, 1, 1);
    errSel = 1; errRd = 1;
    #1;
    chk(errCount == 5, "R7 collision before", int'(errCount), 5);
    @(posedge clk); #1;
    chk(errCount == 1, "R7 collision after", int'(errCount), 1);
    idle();

    // R8 R9 R10 fast channel blocks
    sendBlock(0, 1, 0);
    @(posedge clk); #1;
    chk(crcDone == 1 && crcOk == 1, "R9 good block", int'({crcDone, crcOk}), 3);
    chk(outEn == 0, "R10 no output", int'(outEn), 0);
    bufAddr = 0; #1;
    chk(bufData == lastBlk[0], "R8 first byte", int'(bufData), lastBlk[0]);
    sendBlock(1, 0, 1);
    @(posedge clk); #1;
    chk(crcDone == 1 && crcOk == 0, "R9 corrupt block", int'({crcDone, crcOk}), 2);
    chk(outEn == 0, "R10 window open", int'(outEn), 0);
    sendBlock(0, 0, 0);
    sendBlock(0, 0, 1);
    @(posedge clk); #1;
    chk(crcOk == 1, "R9 fourth block", int'(crcOk), 1);
    bufAddr = 0; #1;
    chk(bufData == lastBlk[0], "R8 wrap", int'(bufData), lastBlk[0]);
    bufAddr = 96; #1;
    chk(bufData == 0, "R8 above range", int'(bufData), 0);
    idle();

    // mixed random traffic checked against the model
    for (int i = 0; i < 4000; i++) begin
      bit d = 1'($urandom_range(0, 1));
      drive(($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1)),
            ($urandom_range(0, 299) == 0), d,
            ($urandom_range(0, 4) == 0) ? !d : d,
            1'($urandom_range(0, 1)), int'($urandom_range(0, NW - 1)));
      errRd = ($urandom_range(0, 40) == 0);
      errSel = 2'($urandom_range(0, NW - 1));
      bufAddr = 7'($urandom_range(0, 127));
    end
    idle();
    repeat (3) @(negedge clk);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule